// File: doc/BRIEF.md
# Clock Safe Mode Controller

This block keeps the safe-mode state of a clock manager for two clock domains. The debug domain covers the debug clocks only. The normal domain covers every other clock. While a domain is in safe mode, the block replaces the effective clock-control outputs of that domain with fixed safe values. The programmed control fields that arrive on its inputs are left as they are. When software releases safe mode, the programmed values appear on the outputs again in the same cycle.

Three events put a domain into safe mode:
- a cold reset, which affects both domains;
- a safe-mode request from the reset manager, which affects the normal domain only;
- a warm reset, whose effect on each domain is set by a per-domain response bit.

Only a software write-one-to-clear access takes a domain out of safe mode. The warm-reset response bits come out of cold reset enabled and keep their value through a warm reset. The block generates no clocks. It only decides which control values reach the clock generators.

Top module: `clk_safe_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge (cold reset), both `safe_norm_o` and `safe_dbg_o` read 1 after that edge, and both warm-reset response bits are set to 1.
- R2: `safe_req` high at an edge sets `safe_norm_o` after that edge. `safe_dbg_o` and the response bits are not changed.
- R3: A write with `sw_wr_en`=1 and `sw_wr_addr`=0 clears `safe_norm_o` if `sw_wr_data[0]`=1 and clears `safe_dbg_o` if `sw_wr_data[1]`=1. A data bit of 0 leaves that domain unchanged. Nothing else clears a domain.
- R4: If a set event (request or enabled warm reset) and a software clear reach the same domain at the same edge, the domain stays in safe mode.
- R5: `warm_rst` high at an edge sets the normal domain if response bit 0 is 1, and sets the debug domain if response bit 1 is 1. A domain whose bit is 0 keeps its state. A write with `sw_wr_addr`=1 loads the response bits from `sw_wr_data[1:0]`. A warm reset in the same cycle as that write uses the old bits.
- R6: The response bits keep their value through a warm reset.
- R7: `pll_byp_o` = `pll_byp_i` OR normal safe mode. `pll_bypsrc_o` is 0 (oscillator 1) in normal safe mode and `pll_bypsrc_i` otherwise.
- R8: In normal safe mode, each `DIV_W`-bit field of `div_o` equals `DIV_DFLT`. Otherwise `div_o` equals `div_i`.
- R9: In normal safe mode, each `SEL_W`-bit field of `flash_sel_o` equals `PERIPH_SEL` (the peripheral PLL). Otherwise `flash_sel_o` equals `flash_sel_i`.
- R10: `clk_en_o` = `clk_en_i` OR normal safe mode. `dbg_en_o` = `dbg_en_i` OR debug safe mode. Each domain forces only its own enables.
- R11: With both domains released, every effective output equals its programmed input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst | input | 1 | Warm reset event, synchronous, active high |
| safe_req | input | 1 | Safe-mode request from the reset manager |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_addr | input | 1 | 0: safe-mode clear (W1C), 1: warm-response bits |
| sw_wr_data | input | 2 | Bit 0 normal domain, bit 1 debug domain |
| pll_byp_i | input | NPLL | Programmed PLL bypass bits |
| pll_bypsrc_i | input | NPLL | Programmed bypass source (0 oscillator 1, 1 PLL reference input) |
| div_i | input | NDIV*DIV_W | Programmed divider settings |
| flash_sel_i | input | NFLASH*SEL_W | Programmed flash clock source selects |
| clk_en_i | input | NEN | Programmed normal-domain clock enables |
| dbg_en_i | input | NDBG | Programmed debug clock enables |
| pll_byp_o | output | NPLL | Effective PLL bypass |
| pll_bypsrc_o | output | NPLL | Effective bypass source |
| div_o | output | NDIV*DIV_W | Effective divider settings |
| flash_sel_o | output | NFLASH*SEL_W | Effective flash clock source selects |
| clk_en_o | output | NEN | Effective normal-domain enables |
| dbg_en_o | output | NDBG | Effective debug enables |
| safe_norm_o | output | 1 | Normal domain in safe mode |
| safe_dbg_o | output | 1 | Debug domain in safe mode |

## Verification
Two kinds of event can reach a domain flag at the same edge. One is a set, from the reset-manager request or an enabled warm reset. The other is a software clear. Separately, a write to the warm-response bits can land in the same cycle as a warm reset. The bench drives these pairs on purpose in directed steps, and a long randomized sweep produces them often. A bench model that gives set priority over clear, and applies a response-bit write only after the edge, predicts the flags. A mismatch in either flag, or in any forced output field, counts as a miscompare.

// File: rtl/csm_pkg.sv
// Package csm_pkg
// Shared domain indices and write-address codes for the safe-mode controller.
// Assumes exactly two safe-mode domains.
package csm_pkg;
    localparam int NUM_DOM = 2;

    typedef enum logic {
        DOM_NORM = 1'b0,
        DOM_DBG  = 1'b1
    } csm_dom_e;

    localparam logic ADDR_CLR = 1'b0;
    localparam logic ADDR_CFG = 1'b1;
endpackage

// File: rtl/csm_domain_state.sv
// Module csm_domain_state
// Holds the safe-mode flag of one clock domain. A set event wins over a clear.
// Cold reset (rst_n low, synchronous) forces the flag on.
// Assumes set_i and clr_i are already decoded for this domain.
module csm_domain_state (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic safe_o
);
    logic safe_q;

    // Flag register: reset on, set has priority over the software clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            safe_q <= 1'b1;
        else if (set_i)
            safe_q <= 1'b1;
        else if (clr_i)
            safe_q <= 1'b0;
    end

    assign safe_o = safe_q;

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> safe_o);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !safe_o);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(safe_o));
endmodule

// File: rtl/csm_warm_cfg.sv
// Module csm_warm_cfg
// Warm-reset response bits, one per domain. Only cold reset initialises them
// (to all ones), so they survive a warm reset. A write replaces all bits.
module csm_warm_cfg #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [NB-1:0] data_i,
    output logic [NB-1:0] cfg_o
);
    logic [NB-1:0] cfg_q;

    // Response register: cold reset to enabled, loaded on a config write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '1;
        else if (wr_i)
            cfg_q <= data_i;
    end

    assign cfg_o = cfg_q;

    assert_cfg_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cfg_o));
endmodule

// File: rtl/csm_override.sv
// Module csm_override
// Combinational forcing of the clock-control fields while a domain is safe.
// Normal safe: bypass all PLLs to oscillator 1, default dividers, flash
// sources on the peripheral PLL, all normal enables on. Debug safe: debug
// enables on. The programmed inputs pass through unchanged otherwise.
module csm_override #(
    parameter int NPLL       = 3,
    parameter int NDIV       = 4,
    parameter int DIV_W      = 4,
    parameter int NFLASH     = 3,
    parameter int SEL_W      = 2,
    parameter int NEN        = 8,
    parameter int NDBG       = 4,
    parameter int DIV_DFLT   = 1,
    parameter int PERIPH_SEL = 2
) (
    input  logic                    safe_norm_i,
    input  logic                    safe_dbg_i,
    input  logic [NPLL-1:0]         pll_byp_i,
    input  logic [NPLL-1:0]         pll_bypsrc_i,
    input  logic [NDIV*DIV_W-1:0]   div_i,
    input  logic [NFLASH*SEL_W-1:0] flash_sel_i,
    input  logic [NEN-1:0]          clk_en_i,
    input  logic [NDBG-1:0]         dbg_en_i,
    output logic [NPLL-1:0]         pll_byp_o,
    output logic [NPLL-1:0]         pll_bypsrc_o,
    output logic [NDIV*DIV_W-1:0]   div_o,
    output logic [NFLASH*SEL_W-1:0] flash_sel_o,
    output logic [NEN-1:0]          clk_en_o,
    output logic [NDBG-1:0]         dbg_en_o
);
    localparam logic [DIV_W-1:0] DIV_SAFE = DIV_W'(DIV_DFLT);
    localparam logic [SEL_W-1:0] SEL_SAFE = SEL_W'(PERIPH_SEL);

    // PLL bypass and source: forced to bypass on oscillator 1
    assign pll_byp_o    = pll_byp_i | {NPLL{safe_norm_i}};
    assign pll_bypsrc_o = safe_norm_i ? '0 : pll_bypsrc_i;

    // Enables: each domain forces only its own gates on
    assign clk_en_o = clk_en_i | {NEN{safe_norm_i}};
    assign dbg_en_o = dbg_en_i | {NDBG{safe_dbg_i}};

    genvar gd;
    generate
        for (gd = 0; gd < NDIV; gd++) begin : g_div
            // One divider field: default value while normal domain is safe
            assign div_o[gd*DIV_W +: DIV_W] =
                safe_norm_i ? DIV_SAFE : div_i[gd*DIV_W +: DIV_W];
        end
        for (gd = 0; gd < NFLASH; gd++) begin : g_flash
            // One flash source select: peripheral PLL while normal is safe
            assign flash_sel_o[gd*SEL_W +: SEL_W] =
                safe_norm_i ? SEL_SAFE : flash_sel_i[gd*SEL_W +: SEL_W];
        end
    endgenerate

    // Immediate checks of the forced values
    always_comb begin
        if (safe_norm_i) begin
            assert_byp_forced_R7: assert ((&pll_byp_o) && (pll_bypsrc_o == '0));
            assert_en_forced_R10: assert (&clk_en_o);
        end
        if (safe_dbg_i) begin
            assert_dbg_forced_R10: assert (&dbg_en_o);
        end
        if (!safe_norm_i && !safe_dbg_i) begin
            assert_passthru_R11: assert ((div_o == div_i) && (flash_sel_o == flash_sel_i)
                && (clk_en_o == clk_en_i) && (dbg_en_o == dbg_en_i));
        end
    end
endmodule

// File: rtl/clk_safe_ctrl.sv
// Module clk_safe_ctrl (top)
// Safe-mode controller for the normal and debug clock domains. It decodes
// the set and clear events per domain, keeps the warm-reset response bits,
// and forces the effective clock-control outputs.
// Assumes that all inputs are synchronous to clk, that rst_n is the cold
// reset, and that warm_rst is a one-cycle event.
module clk_safe_ctrl
    import csm_pkg::*;
#(
    parameter int NPLL       = 3,
    parameter int NDIV       = 4,
    parameter int DIV_W      = 4,
    parameter int NFLASH     = 3,
    parameter int SEL_W      = 2,
    parameter int NEN        = 8,
    parameter int NDBG       = 4,
    parameter int DIV_DFLT   = 1,
    parameter int PERIPH_SEL = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    warm_rst,
    input  logic                    safe_req,
    input  logic                    sw_wr_en,
    input  logic                    sw_wr_addr,
    input  logic [1:0]              sw_wr_data,
    input  logic [NPLL-1:0]         pll_byp_i,
    input  logic [NPLL-1:0]         pll_bypsrc_i,
    input  logic [NDIV*DIV_W-1:0]   div_i,
    input  logic [NFLASH*SEL_W-1:0] flash_sel_i,
    input  logic [NEN-1:0]          clk_en_i,
    input  logic [NDBG-1:0]         dbg_en_i,
    output logic [NPLL-1:0]         pll_byp_o,
    output logic [NPLL-1:0]         pll_bypsrc_o,
    output logic [NDIV*DIV_W-1:0]   div_o,
    output logic [NFLASH*SEL_W-1:0] flash_sel_o,
    output logic [NEN-1:0]          clk_en_o,
    output logic [NDBG-1:0]         dbg_en_o,
    output logic                    safe_norm_o,
    output logic                    safe_dbg_o
);
    logic [NUM_DOM-1:0] warm_cfg;
    logic [NUM_DOM-1:0] dom_set;
    logic [NUM_DOM-1:0] dom_clr;
    logic [NUM_DOM-1:0] dom_safe;
    logic               cfg_wr;

    assign cfg_wr = sw_wr_en && (sw_wr_addr == ADDR_CFG);

    csm_warm_cfg #(.NB(NUM_DOM)) u_warm_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (cfg_wr),
        .data_i(sw_wr_data),
        .cfg_o (warm_cfg)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_DOM; gi++) begin : g_dom
            // Event decode: the request reaches only the normal domain
            assign dom_set[gi] = (warm_rst && warm_cfg[gi])
                               || (safe_req && (gi == int'(DOM_NORM)));
            assign dom_clr[gi] = sw_wr_en && (sw_wr_addr == ADDR_CLR) && sw_wr_data[gi];

            csm_domain_state u_state (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (dom_set[gi]),
                .clr_i (dom_clr[gi]),
                .safe_o(dom_safe[gi])
            );
        end
    endgenerate

    assign safe_norm_o = dom_safe[DOM_NORM];
    assign safe_dbg_o  = dom_safe[DOM_DBG];

    csm_override #(
        .NPLL(NPLL), .NDIV(NDIV), .DIV_W(DIV_W), .NFLASH(NFLASH), .SEL_W(SEL_W),
        .NEN(NEN), .NDBG(NDBG), .DIV_DFLT(DIV_DFLT), .PERIPH_SEL(PERIPH_SEL)
    ) u_override (
        .safe_norm_i (dom_safe[DOM_NORM]),
        .safe_dbg_i  (dom_safe[DOM_DBG]),
        .pll_byp_i   (pll_byp_i),
        .pll_bypsrc_i(pll_bypsrc_i),
        .div_i       (div_i),
        .flash_sel_i (flash_sel_i),
        .clk_en_i    (clk_en_i),
        .dbg_en_i    (dbg_en_i),
        .pll_byp_o   (pll_byp_o),
        .pll_bypsrc_o(pll_bypsrc_o),
        .div_o       (div_o),
        .flash_sel_o (flash_sel_o),
        .clk_en_o    (clk_en_o),
        .dbg_en_o    (dbg_en_o)
    );

    assert_cold_R1: assert property (@(posedge clk)
        !rst_n |=> (safe_norm_o && safe_dbg_o));
    assert_req_norm_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_req && !warm_rst && !(sw_wr_en && sw_wr_addr == ADDR_CLR))
            |=> (safe_norm_o && $stable(safe_dbg_o)));
endmodule

// File: tb/clk_safe_ctrl_bench.sv
`timescale 1ns/1ps
module clk_safe_ctrl_bench;
    localparam int NPLL = 3, NDIV = 4, DIV_W = 4, NFLASH = 3, SEL_W = 2;
    localparam int NEN = 8, NDBG = 4, DIV_DFLT = 1, PERIPH_SEL = 2;
    localparam real CYC = 4.0;

    logic clk = 1'b0;
    logic rst_n, warm_rst, safe_req, sw_wr_en, sw_wr_addr;
    logic [1:0] sw_wr_data;
    logic [NPLL-1:0] pll_byp_i, pll_bypsrc_i, pll_byp_o, pll_bypsrc_o;
    logic [NDIV*DIV_W-1:0] div_i, div_o;
    logic [NFLASH*SEL_W-1:0] flash_sel_i, flash_sel_o;
    logic [NEN-1:0] clk_en_i, clk_en_o;
    logic [NDBG-1:0] dbg_en_i, dbg_en_o;
    logic safe_norm_o, safe_dbg_o;

    int vecs = 0, fails = 0;
    logic m_norm, m_dbg;
    logic [1:0] m_cfg;
    bit done = 0;

    always #(CYC/2) clk = ~clk;

    clk_safe_ctrl u_clk_safe_ctrl (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .safe_req(safe_req),
        .sw_wr_en(sw_wr_en), .sw_wr_addr(sw_wr_addr), .sw_wr_data(sw_wr_data),
        .pll_byp_i(pll_byp_i), .pll_bypsrc_i(pll_bypsrc_i), .div_i(div_i),
        .flash_sel_i(flash_sel_i), .clk_en_i(clk_en_i), .dbg_en_i(dbg_en_i),
        .pll_byp_o(pll_byp_o), .pll_bypsrc_o(pll_bypsrc_o), .div_o(div_o),
        .flash_sel_o(flash_sel_o), .clk_en_o(clk_en_o), .dbg_en_o(dbg_en_o),
        .safe_norm_o(safe_norm_o), .safe_dbg_o(safe_dbg_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every effective output against values computed from the model
    task automatic check_outputs();
        logic [NDIV*DIV_W-1:0] e_div;
        logic [NFLASH*SEL_W-1:0] e_sel;
        for (int i = 0; i < NDIV; i++)
            e_div[i*DIV_W +: DIV_W] = m_norm ? DIV_W'(DIV_DFLT) : div_i[i*DIV_W +: DIV_W];
        for (int i = 0; i < NFLASH; i++)
            e_sel[i*SEL_W +: SEL_W] = m_norm ? SEL_W'(PERIPH_SEL) : flash_sel_i[i*SEL_W +: SEL_W];
        check("R7 bypass", 64'(pll_byp_o), 64'(pll_byp_i | {NPLL{m_norm}}));
        check("R7 bypass source", 64'(pll_bypsrc_o), m_norm ? 64'd0 : 64'(pll_bypsrc_i));
        check("R8 dividers", 64'(div_o), 64'(e_div));
        check("R9 flash selects", 64'(flash_sel_o), 64'(e_sel));
        check("R10 normal enables", 64'(clk_en_o), 64'(clk_en_i | {NEN{m_norm}}));
        check("R10 debug enables", 64'(dbg_en_o), 64'(dbg_en_i | {NDBG{m_dbg}}));
        if (!m_norm && !m_dbg)
            check("R11 passthrough", 64'({div_o, flash_sel_o, clk_en_o, dbg_en_o}),
                  64'({div_i, flash_sel_i, clk_en_i, dbg_en_i}));
    endtask

    // One clock: drive at negedge, advance the model, sample 1 ns after posedge
    task automatic step(input string tag, input logic rn, input logic wr, input logic rq,
                        input logic we, input logic ad, input logic [1:0] d);
        logic n_norm, n_dbg;
        logic [1:0] n_cfg;
        logic s_n, s_d, c_n, c_d;
        @(negedge clk);
        rst_n = rn; warm_rst = wr; safe_req = rq;
        sw_wr_en = we; sw_wr_addr = ad; sw_wr_data = d;
        pll_byp_i = NPLL'($urandom); pll_bypsrc_i = NPLL'($urandom);
        div_i = (NDIV*DIV_W)'($urandom); flash_sel_i = (NFLASH*SEL_W)'($urandom);
        clk_en_i = NEN'($urandom); dbg_en_i = NDBG'($urandom);
        s_n = rq | (wr & m_cfg[0]);
        s_d = wr & m_cfg[1];
        c_n = we & !ad & d[0];
        c_d = we & !ad & d[1];
        n_norm = s_n ? 1'b1 : (c_n ? 1'b0 : m_norm);
        n_dbg  = s_d ? 1'b1 : (c_d ? 1'b0 : m_dbg);
        n_cfg  = (we & ad) ? d : m_cfg;
        if (!rn) begin n_norm = 1'b1; n_dbg = 1'b1; n_cfg = 2'b11; end
        @(posedge clk);
        #1;
        m_norm = n_norm; m_dbg = n_dbg; m_cfg = n_cfg;
        check({tag, " normal status"}, 64'(safe_norm_o), 64'(m_norm));
        check({tag, " debug status"}, 64'(safe_dbg_o), 64'(m_dbg));
        check_outputs();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        #(CYC * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; warm_rst = 0; safe_req = 0; sw_wr_en = 0; sw_wr_addr = 0; sw_wr_data = 0;
        m_norm = 1; m_dbg = 1; m_cfg = 2'b11;
        // R1: cold reset, both domains safe, outputs forced
        step("R1", 0, 0, 0, 0, 0, 2'b00);
        step("R1", 0, 0, 0, 0, 0, 2'b00);
        step("R1 idle", 1, 0, 0, 0, 0, 2'b00);
        // R3: zero data clears nothing, then clear each domain separately
        step("R3 zero data", 1, 0, 0, 1, 0, 2'b00);
        step("R3 clear debug", 1, 0, 0, 1, 0, 2'b10);
        step("R3 clear normal", 1, 0, 0, 1, 0, 2'b01);
        step("R11 released", 1, 0, 0, 0, 0, 2'b00);
        // R1/R5: default response bits put both domains back into safe mode
        step("R5 default warm", 1, 1, 0, 0, 0, 2'b00);
        // R5: response bits 01 -> only the normal domain enters safe mode
        step("R5 cfg write", 1, 0, 0, 1, 1, 2'b01);
        step("R3 clear both", 1, 0, 0, 1, 0, 2'b11);
        step("R5 warm normal only", 1, 1, 0, 0, 0, 2'b00);
        // R6: response bits kept after the warm reset
        step("R3 clear normal", 1, 0, 0, 1, 0, 2'b01);
        step("R6 second warm", 1, 1, 0, 0, 0, 2'b00);
        step("R3 clear normal", 1, 0, 0, 1, 0, 2'b01);
        // R2: the request sets the normal domain only
        step("R2 request", 1, 0, 1, 0, 0, 2'b00);
        // R4: request and clear in the same cycle
        step("R4 request vs clear", 1, 0, 1, 1, 0, 2'b01);
        // R5: warm reset with a response write in the same cycle uses old bits (01)
        step("R5 warm vs cfg write", 1, 1, 0, 1, 1, 2'b10);
        step("R3 clear both", 1, 0, 0, 1, 0, 2'b11);
        step("R5 new cfg warm", 1, 1, 0, 0, 0, 2'b00);
        // R4: enabled warm reset against a debug clear in the same cycle
        step("R4 warm vs clear", 1, 1, 0, 1, 0, 2'b11);
        // Randomized sweep over all event combinations
        for (int n = 0; n < 4000; n++) begin
            logic rn, wr, rq, we, ad;
            logic [1:0] d;
            rn = ($urandom % 64) != 0;
            wr = ($urandom % 6) == 0;
            rq = ($urandom % 6) == 0;
            we = ($urandom % 3) == 0;
            ad = ($urandom % 3) == 0;
            d  = 2'($urandom);
            step("R2/R3/R4/R5/R6 sweep", rn, wr, rq, we, ad, d);
        end
        done = 1;
        finish_run();
    end
endmodule